// File: doc/BRIEF.md
# Multi-Lane Deskew Aligner

This block lines up several parallel data lanes that reach a common clock with different delays. Each lane keeps a small FIFO of its own. A lane ignores its incoming words until it captures the alignment code. At that point its write and read pointers restart at zero, and every later valid word is stored behind the code. While any lane is still waiting, every lane's output holds its last value. When the last lane captures its code, all read pointers are released on the same clock. From then on each lane emits one stored word per cycle, so the alignment codes leave every lane in the same cycle.

Each FIFO has DEPTH entries, and this sets the largest skew the block can absorb. A lane fills up if the other lanes are still waiting while it already holds DEPTH words and it then receives another valid word. When that happens the block pulses an error flag and all lanes go back to searching for the code. With the enable low, each lane bypasses the FIFO and shows its input one cycle later, and all alignment state is cleared.

Top module: `deskew_aligner`

## Requirements
- R1: While reset (rst_n low) is applied, and on the first cycle after it, out_data is all zeros and aligned and err are low.
- R2: A lane ignores any word presented with its valid bit low, even a word equal to the alignment code ALIGN_CODE (default 8'hBC). A valid word that arrives before the lane's first valid code is discarded. The code itself is the first word the lane stores.
- R3: While enabled and before release, every lane's output keeps the value it had in the previous cycle.
- R4: Release happens on the clock edge after the edge at which the last lane captures its code. At release every lane outputs ALIGN_CODE in the same cycle. After that, each lane outputs one stored word per cycle, in arrival order.
- R5: aligned rises in the same cycle as the released codes. It stays high until en goes low or reset is applied.
- R6: Suppose a lane that has captured the code receives a valid word while it already holds DEPTH words (default 8) and not every lane has captured its code. Then err is high for exactly the next cycle, every lane discards its contents and searches for the code again, and the outputs hold.
- R7: While en is low, each lane's output equals its input from the previous cycle, aligned and err are low, and all lanes restart their search when en returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common read/write clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Aligner enable; low selects bypass |
| in_data | input | LANES*W | Per-lane input words, lane l at bits [l*W +: W] |
| in_valid | input | LANES | Per-lane word-valid |
| out_data | output | LANES*W | Per-lane output words, same packing as in_data |
| aligned | output | 1 | Lanes released and aligned |
| err | output | 1 | One-cycle pulse when a lane would overflow before release |

## Verification
A bad per-lane code detector or a bad write pointer shows up at the outputs as a release on the wrong cycle. It can also show up as one lane emitting a word that is shifted against the others. Either fault appears in the first cycle after release. A read pointer that leaves zero early breaks the hold on the outputs before aligned rises, and this is visible in the very next cycle. A wrong fill comparison shows as err firing on the wrong word, or a restart that never happens. With streams whose skews are spread over the whole FIFO, this appears within DEPTH cycles of the first lane's code.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  // Pointer width: one extra bit beyond the index so a full FIFO is distinguishable.
  function automatic int ptr_width(input int depth);
    return $clog2(depth) + 1;
  endfunction

  // Words stored in a lane before release (read pointer parked at zero).
  function automatic int unsigned held_words(input int unsigned wptr,
                                             input int unsigned rptr);
    return wptr - rptr;
  endfunction
endpackage

// File: rtl/deskew_lane.sv
module deskew_lane
  import deskew_pkg::*;
#(
  parameter int W = 8,
  parameter int DEPTH = 8,
  parameter logic [W-1:0] ALIGN_CODE = 8'hBC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         restart,
  input  logic         all_seen,
  input  logic [W-1:0] in_d,
  input  logic         in_v,
  output logic [W-1:0] out_d,
  output logic         seen,
  output logic         ovf_req
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = ptr_width(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          seen_q;
  logic [W-1:0]  out_q;
  logic          code_hit, wr_en;
  logic [AW-1:0] wr_idx;

  assign code_hit = in_v && (in_d == ALIGN_CODE) && !seen_q;
  assign ovf_req  = seen_q && in_v && !all_seen &&
                    (held_words(32'(wptr), 32'(rptr)) == DEPTH);
  assign wr_en    = en && !restart && in_v && (code_hit || seen_q);
  assign wr_idx   = code_hit ? '0 : wptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= in_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      wptr   <= '0;
      rptr   <= '0;
      out_q  <= '0;
    end else if (!en || restart) begin
      seen_q <= 1'b0;
      wptr   <= '0;
      rptr   <= '0;
      if (!en) out_q <= in_d;
    end else begin
      if (all_seen) begin
        out_q <= mem[rptr[AW-1:0]];
        rptr  <= rptr + 1'b1;
      end
      if (code_hit) begin
        seen_q <= 1'b1;
        wptr   <= PW'(1);
        rptr   <= '0;
      end else if (seen_q && in_v) begin
        wptr <= wptr + 1'b1;
      end
    end
  end

  assign out_d = out_q;
  assign seen  = seen_q;

  // R6: before release a lane never holds more than DEPTH words
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !all_seen) |-> (wptr <= PW'(DEPTH)));
  // R3: read pointer stays parked until every lane has its code
  a_r3_rptr_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !all_seen |-> (rptr == '0));
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LANES-1:0] lane_seen,
  input  logic [LANES-1:0] lane_ovf,
  output logic             all_seen,
  output logic             restart,
  output logic             aligned,
  output logic             err
);
  logic aligned_q, err_q;

  assign all_seen = &lane_seen;
  assign restart  = |lane_ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      aligned_q <= en && (aligned_q || all_seen);
      err_q     <= en && restart;
    end
  end

  assign aligned = aligned_q;
  assign err     = err_q;

  // R5: once aligned, stays aligned while enabled
  a_r5_aligned_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && aligned_q) |=> aligned_q);
  // R6: error pulse never coincides with aligned state
  a_r6_err_not_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !aligned_q);
endmodule

// File: rtl/deskew_aligner.sv
module deskew_aligner
  import deskew_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W = 8,
  parameter int DEPTH = 8,
  parameter logic [W-1:0] ALIGN_CODE = 8'hBC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [LANES*W-1:0] in_data,
  input  logic [LANES-1:0]   in_valid,
  output logic [LANES*W-1:0] out_data,
  output logic               aligned,
  output logic               err
);
  logic [LANES-1:0] lane_seen, lane_ovf;
  logic             all_seen, restart;

  deskew_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en),
    .lane_seen(lane_seen), .lane_ovf(lane_ovf),
    .all_seen(all_seen), .restart(restart),
    .aligned(aligned), .err(err)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    deskew_lane #(.W(W), .DEPTH(DEPTH), .ALIGN_CODE(ALIGN_CODE)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(en),
      .restart(restart), .all_seen(all_seen),
      .in_d(in_data[l*W +: W]), .in_v(in_valid[l]),
      .out_d(out_data[l*W +: W]),
      .seen(lane_seen[l]), .ovf_req(lane_ovf[l])
    );
  end

  // R4: at release every lane shows the alignment code together
  a_r4_codes_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> (out_data == {LANES{ALIGN_CODE}}));
  // R3: outputs hold while waiting for the last lane
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && en && !all_seen) |=> $stable(out_data));
  // R7: bypass shows the previous input
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !en) |=> (out_data == $past(in_data)));
  // R6: an error pulse follows a restart of every lane
  a_r6_err_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (lane_seen == '0 && !aligned));
endmodule

// File: tb/deskew_aligner_tb.sv
module deskew_aligner_tb;
  localparam int PERIOD = 10;
  localparam int LANES = 4;
  localparam int W = 8;
  localparam int DEPTH = 8;
  localparam logic [W-1:0] CODE = 8'hBC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [LANES*W-1:0] in_data = '0;
  logic [LANES-1:0]   in_valid = '0;
  logic [LANES*W-1:0] out_data;
  logic aligned, err;

  int errors = 0;
  int checks = 0;
  bit started = 0;
  bit prev_al = 0;
  int err_pulses = 0;
  string ph_req = "R3";

  always #(PERIOD/2) clk = ~clk;

  deskew_aligner #(.LANES(LANES), .W(W), .DEPTH(DEPTH), .ALIGN_CODE(CODE)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .in_data(in_data),
    .in_valid(in_valid), .out_data(out_data), .aligned(aligned), .err(err)
  );

  // Behavioural reference model
  logic [W-1:0] mq [LANES][$];
  bit           m_seen [LANES];
  logic [W-1:0] m_out [LANES];
  bit m_al = 0, m_err = 0, m_byp = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) begin
        mq[l].delete(); m_seen[l] = 0; m_out[l] = '0;
      end
      m_al = 0; m_err = 0; m_byp = 0;
    end else if (!en) begin
      for (int l = 0; l < LANES; l++) begin
        mq[l].delete(); m_seen[l] = 0; m_out[l] = in_data[l*W +: W];
      end
      m_al = 0; m_err = 0; m_byp = 1;
    end else begin
      bit all, ovf;
      m_byp = 0;
      all = 1;
      for (int l = 0; l < LANES; l++) all &= m_seen[l];
      ovf = 0;
      for (int l = 0; l < LANES; l++)
        if (m_seen[l] && in_valid[l] && !all && mq[l].size() == DEPTH) ovf = 1;
      m_err = ovf;
      if (all) begin
        m_al = 1;
        for (int l = 0; l < LANES; l++)
          if (mq[l].size() > 0) m_out[l] = mq[l].pop_front();
      end
      if (ovf) begin
        for (int l = 0; l < LANES; l++) begin mq[l].delete(); m_seen[l] = 0; end
      end else begin
        for (int l = 0; l < LANES; l++) begin
          if (in_valid[l]) begin
            if (m_seen[l]) mq[l].push_back(in_data[l*W +: W]);
            else if (in_data[l*W +: W] == CODE) begin
              m_seen[l] = 1; mq[l].delete(); mq[l].push_back(CODE);
            end
          end
        end
      end
    end
  end

  // Compare against the model away from the active edge
  always @(negedge clk) begin
    if (started) begin
      for (int l = 0; l < LANES; l++) begin
        checks++;
        if (out_data[l*W +: W] !== m_out[l]) begin
          errors++;
          $display("FAIL %s lane %0d out=%h exp=%h", m_byp ? "R7" : (m_al ? "R4" : ph_req),
                   l, out_data[l*W +: W], m_out[l]);
        end
      end
      checks++;
      if (aligned !== m_al) begin
        errors++;
        $display("FAIL R5 aligned=%b exp=%b", aligned, m_al);
      end
      checks++;
      if (err !== m_err) begin
        errors++;
        $display("FAIL R6 err=%b exp=%b", err, m_err);
      end
      if (err === 1'b1) err_pulses++;
      if (aligned === 1'b1 && !prev_al) begin
        checks++; // R4: codes leave all lanes together
        if (out_data !== {LANES{CODE}}) begin
          errors++;
          $display("FAIL R4 release out=%h exp=%h", out_data, {LANES{CODE}});
        end
      end
      prev_al = (aligned === 1'b1);
    end
  end

  function automatic logic [W-1:0] seq_word(input int n);
    if (n < 0) return 8'h00;
    if (n < 3) return 8'(8'h11 * (n + 1));
    if (n == 3) return CODE;
    return 8'(n & 8'h7F);
  endfunction

  task automatic run_phase(input int sk0, input int sk1, input int sk2, input int sk3,
                           input int ncyc, input int fake_lane);
    int sk[LANES];
    sk[0] = sk0; sk[1] = sk1; sk[2] = sk2; sk[3] = sk3;
    for (int t = 0; t < ncyc; t++) begin
      @(negedge clk);
      en = 1'b1;
      for (int l = 0; l < LANES; l++) begin
        in_data[l*W +: W] = seq_word(t - sk[l]);
        in_valid[l] = 1'b1;
        if (l == fake_lane && t < 2) begin
          in_data[l*W +: W] = CODE;  // R2: invalid code must be ignored
          in_valid[l] = 1'b0;
        end
      end
    end
  endtask

  task automatic bypass_phase(input int ncyc);
    for (int t = 0; t < ncyc; t++) begin
      @(negedge clk);
      en = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        in_data[l*W +: W] = 8'((t * 37 + l * 11) & 8'hFF);
        in_valid[l] = t[0];
      end
    end
  endtask

  initial begin
    #(PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_data !== '0 || aligned !== 1'b0 || err !== 1'b0) begin
      errors++;
      $display("FAIL R1 out=%h al=%b err=%b exp=0/0/0", out_data, aligned, err);
    end
    rst_n = 1'b1;
    ph_req = "R3";
    run_phase(0, 3, 6, 2, 30, -1);
    bypass_phase(6);
    // R6: too much skew forces overflow and restart
    err_pulses = 0;
    run_phase(0, 9, 1, 2, 20, -1);
    checks++;
    if (err_pulses != 1) begin
      errors++;
      $display("FAIL R6 err pulses=%0d exp=1", err_pulses);
    end
    bypass_phase(3);
    run_phase(1, 1, 1, 1, 12, -1);
    bypass_phase(2);
    // R2: lane 2 presents the code with valid low before its real code
    ph_req = "R2";
    run_phase(1, 0, 5, 2, 20, 2);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule